// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device side of a 4096-bit serial EEPROM driven over three wires: a select line, a serial clock and a serial data input, with one serial data output that has an enable. A static organisation input makes the array either 256 words of 16 bits or 512 words of 8 bits. The host raises select, clocks in a start bit, a two-bit opcode, an address and, for the data-carrying commands, a data word. Read data is shifted back on the output pin. The storage is a synthesizable register array.

Programming commands are refused until the enable command has been received. They run as a self-timed cycle that begins when select falls, and the cycle length is a parameter counted in system clocks. While a cycle runs, raising select shows busy or ready on the output pin. All three serial inputs are synchronised to a faster system clock, and their edges are detected in that domain.

Top module: `wire3_eeprom`

## Requirements
- R1: A frame is a start bit of 1, then a 2-bit opcode, then the address MSB first: 8 bits when wide mode is selected, 9 bits when narrow mode is selected. Each bit is taken from the data input at a rising edge of the serial clock while select is high, and zeros before the start bit are skipped.
- R2: Opcode 10 reads. At the edge of the last address bit the output goes enabled and shows a 0 dummy bit. Each later rising edge presents the next data bit, MSB first, 16 bits in wide mode and 8 bits in narrow mode.
- R3: A read keeps going after the word with the next address and needs no new address bits. The address wraps from the top word (255 wide, 511 narrow) to 0 while select stays high.
- R4: After reset, programming is disabled. Opcode 00 with the top two address bits 11 enables it and with 00 disables it. While disabled, erase, write, erase-all and write-all change nothing and start no cycle, and reads still work.
- R5: Opcode 01 followed by a data word writes that word to the address. Opcode 11 sets the addressed word to all ones.
- R6: Opcode 00 with the top address bits 01 followed by a data word writes that word to every word (write-all). With the top address bits 10 it sets every word to all ones (erase-all).
- R7: An accepted programming command starts its cycle at the fall of select. If select is raised during the cycle, the output is enabled and reads 0 while busy and 1 once ready. With select low the output is disabled.
- R8: A cycle lasts exactly CYCLE_CLKS system clocks, and the array changes only as it ends. A frame that arrives while the cycle runs is ignored.
- R9: Dropping select before a frame is complete discards the frame. A write whose data field is cut short starts no cycle and changes nothing.
- R10: In wide mode, word n occupies bytes 2n (upper 8 bits) and 2n+1 (lower 8 bits) of the byte array seen in narrow mode.
- R11: After reset every word reads as all ones and the output is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Select; high while a frame is sent |
| skIn | input | 1 | Serial clock |
| diIn | input | 1 | Serial data input |
| orgIn | input | 1 | 1 = 256 x 16, 0 = 512 x 8 |
| doOut | output | 1 | Serial data output (read data or busy/ready) |
| doOe | output | 1 | Output enable for doOut |

## Verification
The hardest case to reach is a frame that arrives while a programming cycle is still running. To reach it, the bench drops select to start a write and raises it again at once. It then clocks a complete second write frame into the device well inside the cycle, and later checks by reading that only the first address changed. Address wrap in both organisations and the byte mapping between the two are reached with directed reads at the top of the array. Randomised writes in both modes are followed by read-back, checked against a bench model of the byte array.

// File: rtl/w3e_pkg.sv
package w3e_pkg;
  parameter int WIDE_AW = 8;
  localparam int NARROW_AW = WIDE_AW + 1;
  localparam int WORD_W = 16;
  localparam int HALF_W = WORD_W / 2;
  localparam int NUM_BYTES = 1 << NARROW_AW;
  localparam int HDR_MAX = 2 + NARROW_AW;

  typedef struct packed {
    logic doWrite;
    logic allWords;
    logic x16;
    logic [NARROW_AW-1:0] addr;
    logic [WORD_W-1:0] data;
  } dpCmd_t;
endpackage

// File: rtl/w3e_data.sv
module w3e_data
  import w3e_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic orgWide,
  input  dpCmd_t cmd,
  input  logic [NARROW_AW-1:0] rdAddr,
  output logic [WORD_W-1:0] rdWord
);
  logic [HALF_W-1:0] mem [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    localparam logic [NARROW_AW-1:0] IDX = NARROW_AW'(g);
    logic hit;
    logic [HALF_W-1:0] val;
    assign hit = cmd.allWords ||
                 (cmd.x16 ? (IDX[NARROW_AW-1:1] == cmd.addr[WIDE_AW-1:0])
                          : (IDX == cmd.addr));
    assign val = (cmd.x16 && !IDX[0]) ? cmd.data[WORD_W-1:HALF_W]
                                      : cmd.data[HALF_W-1:0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '1;
      else if (cmd.doWrite && hit) mem[g] <= val;
    end
  end

  always_comb begin
    if (orgWide)
      rdWord = {mem[{rdAddr[WIDE_AW-1:0], 1'b0}], mem[{rdAddr[WIDE_AW-1:0], 1'b1}]};
    else
      rdWord = {{HALF_W{1'b0}}, mem[rdAddr]};
  end
endmodule

// File: rtl/w3e_ctrl.sv
module w3e_ctrl
  import w3e_pkg::*;
#(
  parameter int CYCLE_CLKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csLvl,
  input  logic skRise,
  input  logic diBit,
  input  logic orgWide,
  input  logic [WORD_W-1:0] rdWord,
  output dpCmd_t dpCmd,
  output logic [NARROW_AW-1:0] rdAddr,
  output logic busy,
  output logic wen,
  output logic doOut,
  output logic doOe
);
  localparam int CNT_W = $clog2(HDR_MAX + WORD_W + 1);
  localparam int BUSY_W = $clog2(CYCLE_CLKS + 1);
  localparam int IDX_W = $clog2(WORD_W);

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_DATA, ST_READ, ST_ARMED, ST_HOLD} st_t;
  typedef enum logic [1:0] {PK_WRITE, PK_ERASE, PK_ERAL, PK_WRAL} pk_t;

  st_t st;
  pk_t kind;
  logic [CNT_W-1:0] cnt;
  logic [HDR_MAX-1:0] hdr;
  logic [NARROW_AW-1:0] addr;
  logic [WORD_W-1:0] dat;
  logic [BUSY_W-1:0] busyCnt;
  logic statusMode, doBit;

  logic [HDR_MAX-1:0] hdrNext;
  logic [CNT_W-1:0] hdrLen, dataLen;
  logic [1:0] opc, sub;
  logic [NARROW_AW-1:0] frameAddr, addrInc;
  logic [IDX_W-1:0] bitIdx;

  always_comb begin
    hdrNext = {hdr[HDR_MAX-2:0], diBit};
    hdrLen = orgWide ? CNT_W'(2 + WIDE_AW) : CNT_W'(2 + NARROW_AW);
    dataLen = orgWide ? CNT_W'(WORD_W) : CNT_W'(HALF_W);
    if (orgWide) begin
      opc = hdrNext[WIDE_AW+1:WIDE_AW];
      sub = hdrNext[WIDE_AW-1:WIDE_AW-2];
      frameAddr = {1'b0, hdrNext[WIDE_AW-1:0]};
      addrInc = {1'b0, addr[WIDE_AW-1:0] + 1'b1};
    end else begin
      opc = hdrNext[NARROW_AW+1:NARROW_AW];
      sub = hdrNext[NARROW_AW-1:NARROW_AW-2];
      frameAddr = hdrNext[NARROW_AW-1:0];
      addrInc = addr + 1'b1;
    end
    bitIdx = IDX_W'(dataLen - 1'b1 - cnt);
  end

  assign rdAddr = addr;
  assign doOut = statusMode ? ~busy : doBit;
  assign doOe = csLvl && (statusMode || (st == ST_READ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind <= PK_WRITE; cnt <= '0; hdr <= '0;
      addr <= '0; dat <= '0; busy <= 1'b0; busyCnt <= '0;
      wen <= 1'b0; statusMode <= 1'b0; doBit <= 1'b0; dpCmd <= '0;
    end else begin
      dpCmd.doWrite <= 1'b0;
      if (busy) begin
        if (busyCnt == BUSY_W'(CYCLE_CLKS - 1)) begin
          busy <= 1'b0;
          dpCmd.doWrite <= 1'b1;
          dpCmd.allWords <= (kind == PK_ERAL) || (kind == PK_WRAL);
          dpCmd.x16 <= orgWide;
          dpCmd.addr <= addr;
          dpCmd.data <= ((kind == PK_ERASE) || (kind == PK_ERAL)) ? '1 : dat;
        end else begin
          busyCnt <= busyCnt + 1'b1;
        end
      end
      if (!csLvl) begin
        if (st == ST_ARMED) begin
          busy <= 1'b1; busyCnt <= '0; statusMode <= 1'b1;
        end
        st <= ST_IDLE;
      end else if (skRise) begin
        case (st)
          ST_IDLE: if (diBit && !busy) begin
            st <= ST_HDR; cnt <= '0; hdr <= '0; statusMode <= 1'b0;
          end
          ST_HDR: begin
            hdr <= hdrNext;
            if (cnt == hdrLen - 1'b1) begin
              cnt <= '0;
              addr <= frameAddr;
              case (opc)
                2'b10: begin st <= ST_READ; doBit <= 1'b0; end
                2'b11: begin kind <= PK_ERASE; st <= wen ? ST_ARMED : ST_HOLD; end
                2'b01: begin kind <= PK_WRITE; st <= ST_DATA; dat <= '0; end
                default: begin
                  if (sub == 2'b11) begin wen <= 1'b1; st <= ST_HOLD; end
                  else if (sub == 2'b00) begin wen <= 1'b0; st <= ST_HOLD; end
                  else if (sub == 2'b10) begin kind <= PK_ERAL; st <= wen ? ST_ARMED : ST_HOLD; end
                  else begin kind <= PK_WRAL; st <= ST_DATA; dat <= '0; end
                end
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            dat <= {dat[WORD_W-2:0], diBit};
            if (cnt == dataLen - 1'b1) st <= wen ? ST_ARMED : ST_HOLD;
            else cnt <= cnt + 1'b1;
          end
          ST_READ: begin
            doBit <= rdWord[bitIdx];
            if (cnt == dataLen - 1'b1) begin
              cnt <= '0; addr <= addrInc;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wire3_eeprom.sv
module wire3_eeprom
  import w3e_pkg::*;
#(
  parameter int CYCLE_CLKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  input  logic orgIn,
  output logic doOut,
  output logic doOe
);
  logic [2:0] skPipe;
  logic [1:0] csPipe, diPipe;
  logic csLvl, skRise, diBit, busy, wen;
  logic [WORD_W-1:0] rdWord;
  logic [NARROW_AW-1:0] rdAddr;
  dpCmd_t dpCmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skPipe <= '0; csPipe <= '0; diPipe <= '0;
    end else begin
      skPipe <= {skPipe[1:0], skIn};
      csPipe <= {csPipe[0], csIn};
      diPipe <= {diPipe[0], diIn};
    end
  end

  assign csLvl = csPipe[1];
  assign diBit = diPipe[1];
  assign skRise = skPipe[1] & ~skPipe[2];

  w3e_ctrl #(.CYCLE_CLKS(CYCLE_CLKS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .csLvl(csLvl), .skRise(skRise), .diBit(diBit),
    .orgWide(orgIn), .rdWord(rdWord), .dpCmd(dpCmd), .rdAddr(rdAddr),
    .busy(busy), .wen(wen), .doOut(doOut), .doOe(doOe)
  );

  w3e_data data_i (
    .clk(clk), .rst_n(rst_n), .orgWide(orgIn), .cmd(dpCmd),
    .rdAddr(rdAddr), .rdWord(rdWord)
  );
endmodule

// File: rtl/w3e_checker.sv
module w3e_checker #(
  parameter int CYCLE_CLKS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic csLvl,
  input logic busy,
  input logic wen,
  input logic doWrite,
  input logic doOut,
  input logic doOe
);
  int busyLen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busyLen <= 0;
    else if (!busy) busyLen <= 0;
    else busyLen <= busyLen + 1;
  end

  AST_START_ON_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(csLvl)); // R7
  AST_BUSY_SHOWS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && doOe) |-> !doOut); // R7
  AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    doWrite |-> wen); // R4
  AST_WRITE_AT_CYCLE_END: assert property (@(posedge clk) disable iff (!rst_n)
    doWrite |-> $fell(busy)); // R8
  AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busyLen == CYCLE_CLKS)); // R8
endmodule

bind wire3_eeprom w3e_checker #(.CYCLE_CLKS(CYCLE_CLKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .csLvl(csLvl), .busy(busy), .wen(wen),
  .doWrite(dpCmd.doWrite), .doOut(doOut), .doOe(doOe)
);

// File: tb/wire3_eeprom_tb_top.sv
module wire3_eeprom_tb_top;
  localparam int CYC = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csIn = 1'b0, skIn = 1'b0, diIn = 1'b0, orgIn = 1'b1;
  logic doOut, doOe;

  int errs = 0;
  int checks = 0;
  logic [7:0] refMem [512];
  logic wenRef = 1'b0;

  always #2 clk = ~clk;

  wire3_eeprom #(.CYCLE_CLKS(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .orgIn(orgIn), .doOut(doOut), .doOe(doOe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] refWord(input logic org, input int a);
    if (org) return {refMem[2*a], refMem[2*a+1]};
    return {8'h00, refMem[a]};
  endfunction

  function automatic void refPut(input logic org, input int a, input logic [15:0] d);
    if (org) begin refMem[2*a] = d[15:8]; refMem[2*a+1] = d[7:0]; end
    else refMem[a] = d[7:0];
  endfunction

  task automatic pulse(input logic b, output logic s);
    diIn = b; tick(3); skIn = 1'b1; tick(5); s = doOut; skIn = 1'b0; tick(3);
  endtask

  task automatic sendHdr(input logic org, input int lead, input logic [1:0] op,
                         input logic [8:0] a, output logic lastDo);
    logic s;
    orgIn = org; csIn = 1'b1; tick(4);
    for (int i = 0; i < lead; i++) pulse(1'b0, s);
    pulse(1'b1, s); pulse(op[1], s); pulse(op[0], s);
    for (int i = (org ? 7 : 8); i >= 0; i--) pulse(a[i], lastDo);
  endtask

  task automatic sendData(input logic org, input logic [15:0] d);
    logic s;
    for (int i = (org ? 15 : 7); i >= 0; i--) pulse(d[i], s);
  endtask

  task automatic finishOp(input logic expectCycle, input string req);
    csIn = 1'b0; tick(5); csIn = 1'b1; tick(6);
    if (expectCycle) begin
      chk(req, {doOe, doOut}, 2'b10);
      tick(CYC);
      chk(req, {doOe, doOut}, 2'b11);
    end else begin
      chk(req, doOe, 1'b0);
    end
    csIn = 1'b0; tick(6);
    chk("R7", doOe, 1'b0);
  endtask

  task automatic doRead(input logic org, input int lead, input int a, input int n, input string req);
    logic s;
    logic [15:0] w;
    int cur;
    sendHdr(org, lead, 2'b10, 9'(a), s);
    chk("R2", {doOe, s}, 2'b10);
    cur = a;
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int i = 0; i < (org ? 16 : 8); i++) begin
        pulse(1'b0, s);
        w = {w[14:0], s};
      end
      chk(req, w, refWord(org, cur));
      cur = org ? ((cur + 1) & 255) : ((cur + 1) & 511);
    end
    csIn = 1'b0; tick(6);
  endtask

  task automatic opWrite(input logic org, input int a, input logic [15:0] d, input string req);
    logic s;
    sendHdr(org, 0, 2'b01, 9'(a), s);
    sendData(org, d);
    finishOp(wenRef, req);
    if (wenRef) refPut(org, a, d);
  endtask

  task automatic opErase(input logic org, input int a, input string req);
    logic s;
    sendHdr(org, 0, 2'b11, 9'(a), s);
    finishOp(wenRef, req);
    if (wenRef) refPut(org, a, 16'hFFFF);
  endtask

  task automatic opSys(input logic org, input logic [1:0] sub, input logic [15:0] d, input string req);
    logic s;
    logic [8:0] a;
    a = org ? {1'b0, sub, 6'b0} : {sub, 7'b0};
    sendHdr(org, 0, 2'b00, a, s);
    if (sub == 2'b11) begin wenRef = 1'b1; csIn = 1'b0; tick(6); end
    else if (sub == 2'b00) begin wenRef = 1'b0; csIn = 1'b0; tick(6); end
    else begin
      if (sub == 2'b01) sendData(org, d);
      finishOp(wenRef, req);
      if (wenRef)
        for (int i = 0; i < 512; i++)
          refMem[i] = (sub == 2'b10) ? 8'hFF : ((org && (i % 2 == 0)) ? d[15:8] : d[7:0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    logic s;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 512; i++) refMem[i] = 8'hFF;
    tick(5); rst_n = 1'b1; tick(4);

    chk("R11", doOe, 1'b0);
    doRead(1'b1, 0, 0, 2, "R11");
    doRead(1'b0, 0, 300, 1, "R11");

    opWrite(1'b1, 5, 16'h1234, "R4");
    doRead(1'b1, 0, 5, 1, "R4");

    opSys(1'b1, 2'b11, 16'h0, "R4");
    opWrite(1'b1, 5, 16'hA5C3, "R7");
    doRead(1'b1, 0, 5, 1, "R5");
    doRead(1'b0, 0, 10, 2, "R10");

    opWrite(1'b0, 511, 16'h003C, "R7");
    opWrite(1'b1, 0, 16'h9E71, "R7");
    doRead(1'b1, 0, 255, 2, "R3");
    doRead(1'b0, 0, 510, 3, "R3");
    doRead(1'b1, 3, 5, 1, "R1");

    opErase(1'b1, 5, "R7");
    doRead(1'b1, 0, 5, 1, "R5");

    opWrite(1'b1, 9, 16'h0F0F, "R7");
    sendHdr(1'b1, 0, 2'b01, 9'd9, s);
    sendData(1'b1, 16'hC0DE);
    csIn = 1'b0; tick(5); csIn = 1'b1; tick(6);
    chk("R8", {doOe, doOut}, 2'b10);
    sendHdr(1'b1, 0, 2'b01, 9'd10, s);
    sendData(1'b1, 16'hBEEF);
    chk("R8", {doOe, doOut}, 2'b10);
    csIn = 1'b0; tick(CYC + 10);
    refPut(1'b1, 9, 16'hC0DE);
    doRead(1'b1, 0, 9, 2, "R8");

    sendHdr(1'b1, 0, 2'b01, 9'd20, s);
    for (int i = 0; i < 4; i++) pulse(1'b0, s);
    csIn = 1'b0; tick(5); csIn = 1'b1; tick(6);
    chk("R9", doOe, 1'b0);
    csIn = 1'b0; tick(6);
    doRead(1'b1, 0, 20, 1, "R9");

    opSys(1'b1, 2'b01, 16'h5AA5, "R6");
    doRead(1'b1, 0, 0, 3, "R6");
    doRead(1'b0, 0, 511, 1, "R6");
    opSys(1'b0, 2'b10, 16'h0, "R6");
    doRead(1'b1, 0, 128, 2, "R6");

    for (int k = 0; k < 16; k++) begin
      logic org;
      int a;
      logic [15:0] d;
      org = 1'($urandom % 2);
      a = org ? int'($urandom % 256) : int'($urandom % 512);
      d = 16'($urandom);
      if (!org) d[15:8] = 8'h00;
      opWrite(org, a, d, "R5");
      doRead(org, 0, a, 1, "R5");
      doRead(~org, 0, org ? 2 * a : a / 2, 1, "R10");
    end

    opSys(1'b0, 2'b00, 16'h0, "R4");
    opWrite(1'b0, 7, 16'h0055, "R4");
    opSys(1'b0, 2'b10, 16'h0, "R4");
    doRead(1'b0, 0, 7, 2, "R4");

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule